// File: doc/BRIEF.md
# Ring-Oscillator PUF Response Generator

This block is the digital side of an oscillator-based physical unclonable function. It sees two banks of free-running ring oscillators, powers only the two it is comparing at any moment, and counts the rising edges of both over a programmable number of system clock cycles. Whichever oscillator produced more edges decides one response bit. Stepping through a sequence of pairs builds a multi-bit response word, which is the device fingerprint.

Software or a neighbouring block sets a response length, a challenge offset and a window length, then pulses `start`. The block raises `busy` while it works. It pulses `done` when the word on `response` is complete, and holds that word until the next start. Bit i of the word compares bank-A oscillator i with bank-B oscillator (i + offset) mod BANK_N. Each selected oscillator is brought through a two-flop synchronizer and an edge detector into its own saturating counter. BANK_N must be a power of two.

Top module: `ropuf_resp_gen`

## Requirements
- R1: After reset, `busy`, `done`, `response`, `enA` and `enB` are all zero.
- R2: While computing response bit i, `enA` has only bit i set and `enB` has only bit (i + chalOff) mod BANK_N set. Every other enable bit is low.
- R3: Response bit i is 1 when the bank-A edge count is strictly greater than the bank-B edge count. It is 0 otherwise, and an exact tie gives 0.
- R4: The word holds respLenM1+1 bits in positions 0..respLenM1. All higher `response` bits are 0.
- R5: Edge counters saturate at 2^CNT_W-1. Two saturated counts form a tie, so the bit is 0.
- R6: All enables are low while `done` is high and while the block is idle.
- R7: A start in idle raises `busy` at the next clock edge. `done` is a one-cycle pulse after the last bit, with `busy` low. `response` keeps its value until the next start.
- R8: The settings are sampled at start. A start pulse or a change of settings while `busy` is high has no effect on the result or the run length.
- R9: Each bit takes a 3-cycle settle phase with cleared counters, then a window of winCycles counting cycles (0 acts as 1), then 1 compare cycle. `busy` is high for exactly L*(W+4) cycles, where L is the response length and W the effective window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a response computation (acted on only when idle) |
| respLenM1 | input | IDX_W | Response length minus one |
| chalOff | input | IDX_W | Challenge offset applied to the bank-B index |
| winCycles | input | WIN_W | Measurement window in clock cycles |
| oscA | input | BANK_N | Bank-A oscillator outputs |
| oscB | input | BANK_N | Bank-B oscillator outputs |
| enA | output | BANK_N | Bank-A oscillator enables |
| enB | output | BANK_N | Bank-B oscillator enables |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when the response is complete |
| response | output | BANK_N | Response word |

## Verification
The hardest case to reach from the ports is a pair of counters that both saturate. In that case a clearly faster bank-A oscillator must still yield 0. The bench narrows the counters to 8 bits and runs a long window, with bank A at the fastest toggle rate and bank B alternating between a half and a quarter of that rate. One run therefore holds both the saturated tie and a saturated-against-unsaturated win. Exact ties also need identical waveforms, which the bench gets because both modelled oscillators start on the same enable edge with equal periods.

// File: rtl/ropuf_pkg.sv
package ropuf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_MEASURE,
    ST_COMPARE,
    ST_DONE
  } ropuf_st_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrResp;
    logic clrCnt;
    logic cntEn;
    logic latchBit;
    logic selOn;
  } ropuf_strb_t;

endpackage

// File: rtl/ropuf_ctrl.sv
module ropuf_ctrl
  import ropuf_pkg::*;
#(
  parameter int BANK_N = 64,
  parameter int WIN_W  = 16,
  localparam int IDX_W = $clog2(BANK_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] respLenM1,
  input  logic [IDX_W-1:0] chalOff,
  input  logic [WIN_W-1:0] winCycles,
  output ropuf_strb_t      strb,
  output logic [IDX_W-1:0] idxA,
  output logic [IDX_W-1:0] idxB,
  output logic             busy,
  output logic             done
);

  localparam logic [WIN_W-1:0] SETTLE_LAST = WIN_W'(2);

  ropuf_st_t        st;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lenM1Q;
  logic [IDX_W-1:0] offQ;
  logic [WIN_W-1:0] winQ;
  logic [WIN_W-1:0] phaseCnt;
  logic [WIN_W-1:0] winLast;

  assign winLast = (winQ == '0) ? '0 : winQ - WIN_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      bitIdx   <= '0;
      lenM1Q   <= '0;
      offQ     <= '0;
      winQ     <= '0;
      phaseCnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            lenM1Q   <= respLenM1;
            offQ     <= chalOff;
            winQ     <= winCycles;
            bitIdx   <= '0;
            phaseCnt <= '0;
            st       <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (phaseCnt == SETTLE_LAST) begin
            phaseCnt <= '0;
            st       <= ST_MEASURE;
          end else begin
            phaseCnt <= phaseCnt + WIN_W'(1);
          end
        end
        ST_MEASURE: begin
          if (phaseCnt == winLast) begin
            phaseCnt <= '0;
            st       <= ST_COMPARE;
          end else begin
            phaseCnt <= phaseCnt + WIN_W'(1);
          end
        end
        ST_COMPARE: begin
          if (bitIdx == lenM1Q) begin
            st <= ST_DONE;
          end else begin
            bitIdx <= bitIdx + IDX_W'(1);
            st     <= ST_SETTLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.clrResp  = (st == ST_IDLE) && start;
    strb.clrCnt   = (st == ST_SETTLE);
    strb.cntEn    = (st == ST_MEASURE);
    strb.latchBit = (st == ST_COMPARE);
    strb.selOn    = (st == ST_SETTLE) || (st == ST_MEASURE) || (st == ST_COMPARE);
  end

  assign idxA = bitIdx;
  assign idxB = bitIdx + offQ;
  assign busy = strb.selOn;
  assign done = (st == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R7
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done)) else $error("busy and done together"); // R7
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(lenM1Q) && $stable(offQ) && $stable(winQ)))
    else $error("settings changed mid-run"); // R8

endmodule

// File: rtl/ropuf_dp.sv
module ropuf_dp
  import ropuf_pkg::*;
#(
  parameter int BANK_N = 64,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(BANK_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ropuf_strb_t       strb,
  input  logic [IDX_W-1:0]  idxA,
  input  logic [IDX_W-1:0]  idxB,
  input  logic [BANK_N-1:0] oscA,
  input  logic [BANK_N-1:0] oscB,
  output logic [BANK_N-1:0] enA,
  output logic [BANK_N-1:0] enB,
  output logic [BANK_N-1:0] response
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int SIDES = 2;

  logic [SIDES-1:0] selOsc;
  logic [2:0]       syncQ [SIDES];
  logic [CNT_W-1:0] cnt   [SIDES];

  assign selOsc[0] = oscA[idxA];
  assign selOsc[1] = oscB[idxB];

  always_comb begin
    enA = '0;
    enB = '0;
    if (strb.selOn) begin
      enA[idxA] = 1'b1;
      enB[idxB] = 1'b1;
    end
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic rise;
    assign rise = syncQ[s][1] & ~syncQ[s][2];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ[s] <= '0;
        cnt[s]   <= '0;
      end else begin
        syncQ[s] <= {syncQ[s][1:0], selOsc[s]};
        if (strb.clrCnt) begin
          cnt[s] <= '0;
        end else if (strb.cntEn && rise && (cnt[s] != CNT_MAX)) begin
          cnt[s] <= cnt[s] + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      response <= '0;
    end else if (strb.clrResp) begin
      response <= '0;
    end else if (strb.latchBit) begin
      response[idxA] <= (cnt[0] > cnt[1]);
    end
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (cnt[0] == CNT_MAX && !strb.clrCnt) |=> (cnt[0] == CNT_MAX))
    else $error("counter left saturation"); // R5
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> (cnt[0] == '0 && cnt[1] == '0))
    else $error("counters not cleared in settle"); // R9
  AST_EN_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(enA) && ($countones(enA) == $countones(enB)))
    else $error("enables not a single pair"); // R2

endmodule

// File: rtl/ropuf_resp_gen.sv
module ropuf_resp_gen
  import ropuf_pkg::*;
#(
  parameter int BANK_N = 64,
  parameter int CNT_W  = 16,
  parameter int WIN_W  = 16,
  localparam int IDX_W = $clog2(BANK_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IDX_W-1:0]  respLenM1,
  input  logic [IDX_W-1:0]  chalOff,
  input  logic [WIN_W-1:0]  winCycles,
  input  logic [BANK_N-1:0] oscA,
  input  logic [BANK_N-1:0] oscB,
  output logic [BANK_N-1:0] enA,
  output logic [BANK_N-1:0] enB,
  output logic              busy,
  output logic              done,
  output logic [BANK_N-1:0] response
);

  ropuf_strb_t      strb;
  logic [IDX_W-1:0] idxA;
  logic [IDX_W-1:0] idxB;

  ropuf_ctrl #(.BANK_N(BANK_N), .WIN_W(WIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .respLenM1(respLenM1),
    .chalOff(chalOff), .winCycles(winCycles), .strb(strb),
    .idxA(idxA), .idxB(idxB), .busy(busy), .done(done)
  );

  ropuf_dp #(.BANK_N(BANK_N), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idxA(idxA), .idxB(idxB),
    .oscA(oscA), .oscB(oscB), .enA(enA), .enB(enB), .response(response)
  );

  AST_EN_OFF_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (done || !busy) |-> (enA == '0 && enB == '0))
    else $error("enables high outside a run"); // R6

endmodule

// File: tb/ropuf_resp_gen_tb.sv
module ropuf_resp_gen_tb;

  localparam int N     = 64;
  localparam int CW    = 8;
  localparam int WW    = 16;
  localparam int IW    = $clog2(N);
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] respLenM1 = '0;
  logic [IW-1:0] chalOff = '0;
  logic [WW-1:0] winCycles = '0;
  logic [N-1:0]  oscA = '0;
  logic [N-1:0]  oscB = '0;
  logic [N-1:0]  enA, enB, response;
  logic          busy, done;

  int hA [N];
  int hB [N];
  int tA [N];
  int tB [N];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ropuf_resp_gen #(.BANK_N(N), .CNT_W(CW), .WIN_W(WW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .respLenM1(respLenM1),
    .chalOff(chalOff), .winCycles(winCycles), .oscA(oscA), .oscB(oscB),
    .enA(enA), .enB(enB), .busy(busy), .done(done), .response(response)
  );

  // oscillator models: toggle every h cycles while enabled
  always @(negedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (!enA[k]) begin oscA[k] <= 1'b0; tA[k] <= 0; end
      else if (tA[k] >= hA[k] - 1) begin oscA[k] <= ~oscA[k]; tA[k] <= 0; end
      else tA[k] <= tA[k] + 1;
      if (!enB[k]) begin oscB[k] <= 1'b0; tB[k] <= 0; end
      else if (tB[k] >= hB[k] - 1) begin oscB[k] <= ~oscB[k]; tB[k] <= 0; end
      else tB[k] <= tB[k] + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int estCnt(int h, int w);
    int c;
    c = w / (2 * h);
    return (c > CMAX) ? CMAX : c;
  endfunction

  task automatic runOne(input int len, input int off, input int win, input bit disturb);
    logic [N-1:0] expResp;
    int weff, busyCnt, ib;
    weff = (win == 0) ? 1 : win;
    expResp = '0;
    for (int i = 0; i < len; i++) begin
      ib = (i + off) % N;
      expResp[i] = estCnt(hA[i], weff) > estCnt(hB[ib], weff);
    end
    @(negedge clk);
    respLenM1 = IW'(len - 1);
    chalOff = IW'(off);
    winCycles = WW'(win);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after start", busy, 1);
    check(enA == (N'(1) << 0) && enB == (N'(1) << off), "R2", "pair for bit 0",
          enB, N'(1) << off);
    if (disturb) begin
      respLenM1 = IW'(len + 3);
      chalOff = IW'(off + 5);
      winCycles = WW'(win + 17);
      start = 1'b1;
    end
    busyCnt = 0;
    while (!done && busyCnt < 60000) begin
      if (busy) busyCnt++;
      if (busyCnt == 2 * (weff + 4) + 2 && len > 2)
        check(enA == (N'(1) << 2) && enB == (N'(1) << ((2 + off) % N)), "R2",
              "pair for bit 2", enB, N'(1) << ((2 + off) % N));
      @(negedge clk);
      start = 1'b0;
    end
    check(done == 1'b1 && busy == 1'b0, "R7", "done pulse with busy low", {busy, done}, 2'b01);
    check(enA == '0 && enB == '0, "R6", "enables low at done", enA | enB, 0);
    check(busyCnt == len * (weff + 4), (disturb ? "R8" : "R9"), "busy cycles",
          busyCnt, len * (weff + 4));
    for (int i = 0; i < N; i++) begin
      if (i < len)
        check(response[i] == expResp[i], (disturb ? "R8" : "R3"),
              $sformatf("bit %0d off %0d", i, off), response[i], expResp[i]);
    end
    check((response >> len) == '0 || len == N, "R4", "bits above length", response, expResp);
    @(negedge clk);
    check(done == 1'b0, "R7", "done one cycle", done, 0);
    @(negedge clk);
    @(negedge clk);
    check(response == expResp, "R7", "response held", response, expResp);
    check(enA == '0 && enB == '0 && !busy, "R6", "enables low idle", enA | enB, 0);
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin
      hA[k] = 1 + (k % 4);
      hB[k] = 1 + ((k / 2) % 4);
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && response == '0 && enA == '0 && enB == '0, "R1",
          "reset state", {busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && response == '0, "R1", "after reset release", response, 0);
    runOne(64, 0, 200, 1'b0);
    runOne(64, 1, 200, 1'b0);
    runOne(64, 37, 200, 1'b0);
    runOne(5, 63, 200, 1'b0);
    runOne(1, 0, 200, 1'b0);
    runOne(2, 9, 0, 1'b0);
    runOne(6, 3, 150, 1'b1);
    // saturation: bank A fastest, bank B alternating two slower rates
    for (int k = 0; k < N; k++) begin
      hA[k] = 1;
      hB[k] = (k % 2) ? 4 : 2;
    end
    runOne(8, 0, 1200, 1'b0);
    runOne(8, 1, 1200, 1'b0);
    check(estCnt(1, 1200) == CMAX && estCnt(2, 1200) == CMAX, "R5",
          "saturated tie model", estCnt(2, 1200), CMAX);
    check(response[0] == 1'b1 && response[1] == 1'b0, "R5", "sat tie gives 0",
          response[1:0], 2'b01);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule